// File: doc/BRIEF.md
# Decoded Instruction Cache with Hashed Index

This block keeps instructions that have already been decoded, so that a fetch address seen before can skip the decoder. It is a direct-mapped table. Each entry holds the full fetch address as its tag and the decoded word as its data. A lookup presents an address and gets back, one clock later, a hit flag and the stored word. When the lookup misses and the decoder then succeeds, the decoder's owner writes the address and word back through the fill port. The flush input empties the whole table.

Instruction addresses are always even, so the address is halved before it is hashed. The index joins the low bits of the halved address with bits taken from well above them. A tight local loop and a far-away called routine can then occupy different entries instead of evicting each other.

An empty entry is marked by an all-ones tag. For that reason every lookup and fill address is first compared with the configured memory limit, and an address at or above the limit is reported out of bound. Clearing the table, after reset and on a flush request, is a sweep that writes one entry per clock.

Top module: `dec_cache`

## Requirements
- R1: After reset, `busy` is high for exactly DEPTH = 2^IDX_W cycles and all three response outputs are low. Every lookup accepted after that misses.
- R2: A lookup is accepted when `lk_valid` is high and `busy` is low, and `lk_done` is high in the cycle after that. In any other cycle `lk_done` is low.
- R3: A lookup hits only when the selected entry's tag equals the full, unshifted lookup address. A different address that maps to the same index misses.
- R4: The entry index is computed as follows. Let a = addr >> 1. The index is (a mod 2^LOW_W) | ((a >> HI_SHIFT) << LOW_W), taken mod DEPTH. Addresses with different indices stay resident together, and a fill evicts only the entry at its own index.
- R5: A lookup address >= ADDR_LIMIT returns `lk_oob` = 1 with `lk_hit` = 0. A fill to such an address writes nothing.
- R6: A fill writes its entry only when `fill_valid` and `fill_ok` are both high. With `fill_ok` = 0 (failed decode) the table is unchanged.
- R7: A `flush` pulse while not busy raises `busy` on the next cycle and holds it for DEPTH cycles. After that, every previously filled address misses.
- R8: While `busy` is high, lookups are refused (`lk_done` stays low) and fills write nothing.
- R9: If a fill and a lookup to the same index arrive in the same cycle, the lookup sees the entry as the fill leaves it. It hits with the fill data when the two addresses are equal, and misses otherwise.
- R10: On a miss or a refused lookup, `lk_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; starts a clearing sweep |
| flush | input | 1 | Request to invalidate every entry |
| busy | output | 1 | Clearing sweep in progress |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup fetch address |
| lk_done | output | 1 | Registered response valid |
| lk_hit | output | 1 | Lookup found a matching entry |
| lk_oob | output | 1 | Lookup address at or above the limit |
| lk_data | output | DATA_W | Decoded word on a hit, zero otherwise |
| fill_valid | input | 1 | Fill request after a miss |
| fill_ok | input | 1 | Decode succeeded; the fill may write |
| fill_addr | input | ADDR_W | Address to store as the tag |
| fill_data | input | DATA_W | Decoded word to store |

## Verification
The assertions check the following on every cycle:
- the one-cycle response timing, and that lookups are refused while the sweep runs;
- the out-of-bound flag, and that it never comes with a hit;
- that a miss carries zero data;
- that a flush request raises `busy`.

Other behaviour only shows up over a sequence, so only the bench's scenarios can show it:
- the index hash, together with the full-tag compare and aliasing between addresses;
- that a failed decode leaves the table alone;
- the write-first result when a fill and a lookup hit the same index in one cycle;
- the exact length of the sweep and the empty table that follows it.

The bench covers these with a long run of mixed fills and lookups, checked against a reference table held in the bench.

// File: rtl/dec_cache.sv
module dec_cache #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int IDX_W    = 12,
  parameter int LOW_W    = 8,
  parameter int HI_SHIFT = 12,
  parameter logic [ADDR_W-1:0] ADDR_LIMIT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  output logic              busy,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_done,
  output logic              lk_hit,
  output logic              lk_oob,
  output logic [DATA_W-1:0] lk_data,
  input  logic              fill_valid,
  input  logic              fill_ok,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << LOW_W) - 64'd1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  function automatic logic [IDX_W-1:0] hash_idx(input logic [ADDR_W-1:0] addr);
    logic [ADDR_W-1:0] half, mix;
    half = addr >> 1;
    mix  = (half & LOW_MASK) | ((half >> HI_SHIFT) << LOW_W);
    return mix[IDX_W-1:0];
  endfunction

  logic [ADDR_W-1:0] tag_mem  [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];

  logic              busy_q;
  logic [IDX_W-1:0]  sweep_q;
  logic              done_q, hit_q, oob_q;
  logic [DATA_W-1:0] data_q;

  logic [IDX_W-1:0] lk_idx, fill_idx;
  logic lk_go, lk_in, fill_we, fwd, hit_now;
  logic [ADDR_W-1:0] rd_tag;
  logic [DATA_W-1:0] rd_data;

  assign lk_idx   = hash_idx(lk_addr);
  assign fill_idx = hash_idx(fill_addr);
  assign lk_go    = lk_valid & ~busy_q;
  assign lk_in    = lk_addr < ADDR_LIMIT;
  assign fill_we  = fill_valid & fill_ok & ~busy_q & (fill_addr < ADDR_LIMIT);
  assign fwd      = fill_we & (fill_idx == lk_idx);
  assign rd_tag   = fwd ? fill_addr : tag_mem[lk_idx];
  assign rd_data  = fwd ? fill_data : data_mem[lk_idx];
  assign hit_now  = lk_go & lk_in & (rd_tag == lk_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b1;
      sweep_q <= '0;
      done_q  <= 1'b0;
      hit_q   <= 1'b0;
      oob_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      if (busy_q) begin
        sweep_q <= sweep_q + 1'b1;
        if (sweep_q == LAST) busy_q <= 1'b0;
      end else if (flush) begin
        busy_q  <= 1'b1;
        sweep_q <= '0;
      end
      done_q <= lk_go;
      hit_q  <= hit_now;
      oob_q  <= lk_go & ~lk_in;
      data_q <= hit_now ? rd_data : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (busy_q) begin
      tag_mem[sweep_q]  <= '1;
      data_mem[sweep_q] <= '0;
    end else if (fill_we) begin
      tag_mem[fill_idx]  <= fill_addr;
      data_mem[fill_idx] <= fill_data;
    end
  end

  assign busy    = busy_q;
  assign lk_done = done_q;
  assign lk_hit  = hit_q;
  assign lk_oob  = oob_q;
  assign lk_data = data_q;
endmodule

// File: rtl/dec_cache_chk.sv
module dec_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter logic [ADDR_W-1:0] ADDR_LIMIT = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              busy,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_done,
  input logic              lk_hit,
  input logic              lk_oob,
  input logic [DATA_W-1:0] lk_data
);
  assert_accept_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !busy) |=> lk_done);

  assert_idle_no_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_done);

  assert_refuse_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && busy) |=> !lk_done);

  assert_oob_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !busy && lk_addr >= ADDR_LIMIT) |=> (lk_oob && !lk_hit));

  assert_hit_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !busy && lk_addr < ADDR_LIMIT) |=> !lk_oob);

  assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_data == '0));

  assert_flush_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !busy) |=> busy);
endmodule

bind dec_cache dec_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_LIMIT(ADDR_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .busy(busy),
  .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_done(lk_done),
  .lk_hit(lk_hit), .lk_oob(lk_oob), .lk_data(lk_data)
);

// File: tb/tb_dec_cache.sv
`timescale 1ns/1ps
module tb_dec_cache;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int IW = 6;
  localparam int DEPTH = 1 << IW;
  localparam logic [AW-1:0] LIMIT = 16'hC000;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic lk_valid = 1'b0, fill_valid = 1'b0, fill_ok = 1'b0;
  logic [AW-1:0] lk_addr = '0, fill_addr = '0;
  logic [DW-1:0] fill_data = '0;
  logic busy, lk_done, lk_hit, lk_oob;
  logic [DW-1:0] lk_data;

  int tests = 0, fails = 0;
  logic [AW-1:0] m_tag [DEPTH];
  logic [DW-1:0] m_data [DEPTH];

  always #4 clk = ~clk;

  dec_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .LOW_W(3), .HI_SHIFT(5), .ADDR_LIMIT(LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .busy(busy),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_done(lk_done), .lk_hit(lk_hit),
    .lk_oob(lk_oob), .lk_data(lk_data), .fill_valid(fill_valid), .fill_ok(fill_ok),
    .fill_addr(fill_addr), .fill_data(fill_data)
  );

  function automatic int midx(input int addr);
    int a;
    a = addr / 2;
    return (a % 8 + (a / 32) * 8) % DEPTH;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < DEPTH; i++) begin
      m_tag[i] = '1;
      m_data[i] = '0;
    end
  endtask

  task automatic model_fill(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit ok);
    if (ok && a < LIMIT) begin
      m_tag[midx(int'(a))] = a;
      m_data[midx(int'(a))] = d;
    end
  endtask

  function automatic logic [34:0] expect_lk(input logic [AW-1:0] a);
    bit o, h;
    o = a >= LIMIT;
    h = !o && (m_tag[midx(int'(a))] == a);
    return {1'b1, o, h, h ? m_data[midx(int'(a))] : 32'h0};
  endfunction

  task automatic do_fill(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit ok);
    fill_valid = 1'b1; fill_ok = ok; fill_addr = a; fill_data = d;
    @(negedge clk);
    fill_valid = 1'b0; fill_ok = 1'b0;
  endtask

  task automatic do_look(input logic [AW-1:0] a, output logic [34:0] r);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    r = {lk_done, lk_oob, lk_hit, lk_data};
  endtask

  task automatic look_chk(input logic [AW-1:0] a, input string req);
    logic [34:0] r, e;
    e = expect_lk(a);
    do_look(a, r);
    chk(r == e, req, 64'(r), 64'(e));
  endtask

  initial begin
    int cnt;
    logic [34:0] r;
    logic [15:0] lcg;
    model_clear();
    repeat (3) @(negedge clk);
    chk({busy, lk_done, lk_hit, lk_oob} == 4'b1000, "R1 reset outputs", 64'({busy, lk_done, lk_hit, lk_oob}), 64'h8);
    rst_n = 1'b1;
    cnt = 0;
    while (busy && cnt < 1000) begin cnt++; @(negedge clk); end
    chk(cnt == DEPTH, "R1 sweep length", 64'(cnt), 64'(DEPTH));
    for (int i = 0; i < 8; i++) look_chk(16'(i * 2 + 16'h0200), "R1 empty after reset");

    // R2: no response without a request
    @(negedge clk);
    chk(!lk_done, "R2 idle no done", 64'(lk_done), 64'h0);

    // R3/R4 aliasing: 0x0000 and 0x0010 share index 0
    do_fill(16'h0000, 32'hA0A0_0000, 1'b1); model_fill(16'h0000, 32'hA0A0_0000, 1'b1);
    look_chk(16'h0000, "R3 exact tag hit");
    look_chk(16'h0010, "R3 alias miss");
    // R4 distinct indices coexist: 0x0002 idx1, 0x0042 idx9
    do_fill(16'h0002, 32'h1111_0002, 1'b1); model_fill(16'h0002, 32'h1111_0002, 1'b1);
    do_fill(16'h0042, 32'h2222_0042, 1'b1); model_fill(16'h0042, 32'h2222_0042, 1'b1);
    look_chk(16'h0002, "R4 local resident");
    look_chk(16'h0042, "R4 remote resident");
    do_fill(16'h0010, 32'hB0B0_0010, 1'b1); model_fill(16'h0010, 32'hB0B0_0010, 1'b1);
    look_chk(16'h0000, "R4 evicted by alias");
    look_chk(16'h0010, "R4 new alias hit");

    // R5 out of bound
    look_chk(16'hC000, "R5 oob at limit");
    look_chk(16'hFFFE, "R5 oob high");
    do_fill(16'hC002, 32'hDEAD_BEEF, 1'b1);
    look_chk(16'h0002, "R5 oob fill wrote nothing");
    look_chk(16'hBFFE, "R5 just below limit");

    // R6 failed decode
    do_fill(16'h0004, 32'h5555_5555, 1'b0);
    look_chk(16'h0004, "R6 failed fill no write");

    // R9 same-cycle fill and lookup
    fill_valid = 1'b1; fill_ok = 1'b1; fill_addr = 16'h0100; fill_data = 32'h9999_0100;
    lk_valid = 1'b1; lk_addr = 16'h0100;
    model_fill(16'h0100, 32'h9999_0100, 1'b1);
    @(negedge clk);
    fill_valid = 1'b0; lk_valid = 1'b0;
    r = {lk_done, lk_oob, lk_hit, lk_data};
    chk(r == expect_lk(16'h0100), "R9 fill forwarded", 64'(r), 64'(expect_lk(16'h0100)));
    fill_valid = 1'b1; fill_ok = 1'b1; fill_addr = 16'h0110; fill_data = 32'h9999_0110;
    lk_valid = 1'b1; lk_addr = 16'h0100;
    model_fill(16'h0110, 32'h9999_0110, 1'b1);
    @(negedge clk);
    fill_valid = 1'b0; lk_valid = 1'b0;
    r = {lk_done, lk_oob, lk_hit, lk_data};
    chk(r == expect_lk(16'h0100), "R9 same index other addr misses", 64'(r), 64'(expect_lk(16'h0100)));

    // R4/R6/R10 sweep against the model
    lcg = 16'h1ACE;
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] fa, la;
      logic [DW-1:0] fd;
      bit ok;
      lcg = lcg * 16'd25173 + 16'd13849;
      fa = lcg & 16'hFFFE;
      fd = {lcg, ~lcg} ^ 32'(k);
      ok = (k % 5) != 0;
      do_fill(fa, fd, ok); model_fill(fa, fd, ok);
      lcg = lcg * 16'd25173 + 16'd13849;
      la = (k % 2 == 0) ? fa : ((k % 3 == 0) ? (fa ^ 16'h0010) : (lcg & 16'hFFFE));
      look_chk(la, "R4 R6 R10 mixed sweep");
    end

    // R7/R8 flush, refused lookups, ignored fills
    do_fill(16'h0300, 32'h7777_0300, 1'b1); model_fill(16'h0300, 32'h7777_0300, 1'b1);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk(busy == 1'b1, "R7 busy after flush", 64'(busy), 64'h1);
    do_look(16'h0300, r);
    chk(r == 35'h0, "R8 lookup refused while busy", 64'(r), 64'h0);
    do_fill(16'h0400, 32'h4444_0400, 1'b1);
    cnt = 2;
    while (busy && cnt < 1000) begin cnt++; @(negedge clk); end
    chk(cnt == DEPTH, "R7 flush sweep length", 64'(cnt), 64'(DEPTH));
    model_clear();
    look_chk(16'h0300, "R7 flushed entry misses");
    look_chk(16'h0400, "R8 fill while busy ignored");
    look_chk(16'h0100, "R7 flushed forwarded entry misses");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule